// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a word-addressed requester and a slower backing memory. Each request address is cut into three fields: tag, set index and word-in-line offset. The set index picks one of the sets. Each set holds two lines, called ways, and the stored tags of both ways are compared against the request tag at the same moment. A match on a valid way is a hit.

On a miss the controller picks a victim way. It fills an empty way before it evicts anything. When both ways of the set are valid, a one-bit least-recently-used marker per set decides which way goes. The controller then fetches the whole line over a request/acknowledge memory port, installs the new tag and looks the access up again. The retried lookup completes as a hit.

Writes allocate on a miss. Once the word is in the line, every write is also sent through to memory, so the cache never holds dirty data.

The requester raises `req_valid` and holds its fields steady until `req_done` pulses for one cycle. It then drops `req_valid`. The default build has 64 sets of two ways (128 lines), four 32-bit words per line and a 16-bit word address.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset every line is empty: `req_done` and `mem_req` are low, and the first access to any address is reported with `req_hit` = 0.
- R2: With default parameters, the word address splits into tag = `addr[15:8]`, set = `addr[7:2]` and offset = `addr[1:0]`. The set is the block number (`addr >> 2`) modulo 64. A read returns the memory word at exactly `req_addr`, even when two addresses share a set and differ only in the tag.
- R3: A read miss raises `mem_req` with `mem_we` = 0 and `mem_addr` line-aligned (offset bits zero). `mem_req` and `mem_addr` stay steady until `mem_ack`. The line arrives on `mem_rdata`, with word k at bits `[32k+31:32k]`. The access then completes with the correct word and `req_hit` = 0.
- R4: A second access to a line already present completes with `req_hit` = 1 and issues no line fetch.
- R5: Two blocks that map to the same set occupy both ways side by side. Examples are blocks 0 and 64 (set 0) and blocks 5 and 69 (set 5). While a way of the set is empty, a miss never evicts a valid line, and no two ways of a set ever match the same tag.
- R6: A third block mapped to a full set evicts the way used least recently. The other way stays resident.
- R7: Every hit and every fill marks the touched way as most recently used. A later eviction in that set therefore removes the other way.
- R8: A write to a resident word completes with `req_hit` = 1 and updates the cached copy. It also issues one memory write (`mem_we` = 1, `mem_addr` = `req_addr`, `mem_wdata` = `req_wdata`). A later read returns the new value.
- R9: A write to an absent word first fetches the line, then merges the new word and writes it through. The access reports `req_hit` = 0, and later reads of that line hit and return the new word.
- R10: While a fill or a write-through waits for `mem_ack`, the requester is stalled: `req_done` stays low. `req_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until `req_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with `req_done` |
| req_hit | output | 1 | Access found its line on first lookup, valid with `req_done` |
| mem_req | output | 1 | Memory request (fill or write-through) |
| mem_we | output | 1 | 1 = write-through, 0 = line fetch |
| mem_addr | output | ADDR_W | Line-aligned for fetch, word address for write |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ack | input | 1 | One-cycle acknowledge of the memory request |
| mem_rdata | input | DATA_W*WORDS | Whole fetched line, valid with `mem_ack` |

## Verification
A corrupted valid bit or tag shows up on the next access to the affected set. A lost line produces an extra fetch and `req_hit` = 0. A false match produces wrong `req_rdata` with `req_hit` = 1. Both are visible in the same transaction, within a few cycles of the request. A wrong LRU bit stays hidden until the set is full and a third block arrives; it then shows as the wrong block surviving, detected one access later by an unexpected miss. A bad write path appears either on the write-through port during the write itself, or as stale data on the following read.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_RELOOK,
    ST_WMEM,
    ST_DONE
  } cache_state_e;
endpackage

// File: rtl/cache2w_tag_way.sv
module cache2w_tag_way #(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS),
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_q;

  // tag storage: no reset, registered read, block-RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // valid bits live in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      rd_valid <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/cache2w_data_lane.sv
module cache2w_data_lane #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             evict_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             used_way
);
  // one bit per set: the way to evict next
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (upd_en) lru_q[upd_idx] <= ~used_way;
  end

  assign evict_way = lru_q[rd_idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 64,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_done,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int WAYS = 2;

  cache_state_e      state;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_write;
  logic              missed_q;
  logic              victim_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_q;

  logic [TAG_W-1:0]  lat_tag;
  logic [IDX_W-1:0]  lat_idx;
  logic [OFF_W-1:0]  lat_off;
  logic [IDX_W-1:0]  rd_idx;

  assign lat_tag = lat_addr[ADDR_W-1 -: TAG_W];
  assign lat_idx = lat_addr[OFF_W +: IDX_W];
  assign lat_off = lat_addr[OFF_W-1:0];
  assign rd_idx  = (state == ST_IDLE) ? req_addr[OFF_W +: IDX_W] : lat_idx;

  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [WAYS-1:0]   way_valid;
  logic [WAYS-1:0]   hit_vec;
  logic [DATA_W-1:0] lane_rd   [WAYS][WORDS];
  logic              any_hit;
  logic              hit_way;
  logic              lru_evict;
  logic              victim;
  logic              fill_we;
  logic              wr_hit;
  logic              lru_upd;
  logic              lru_way;
  logic [DATA_W-1:0] hit_word;

  // ---------------- storage per way ----------------
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_tag_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (rd_idx),
      .rd_tag   (way_tag[w]),
      .rd_valid (way_valid[w]),
      .wr_en    (fill_we && (victim_q == 1'(w))),
      .wr_idx   (lat_idx),
      .wr_tag   (lat_tag)
    );

    assign hit_vec[w] = way_valid[w] && (way_tag[w] == lat_tag);

    for (genvar l = 0; l < WORDS; l++) begin : g_lane
      logic              lane_we;
      logic [DATA_W-1:0] lane_wd;
      assign lane_we = (fill_we && (victim_q == 1'(w))) ||
                       (wr_hit && (hit_way == 1'(w)) && (lat_off == OFF_W'(l)));
      assign lane_wd = fill_we ? mem_rdata[l*DATA_W +: DATA_W] : lat_wdata;

      cache2w_data_lane #(.DEPTH(SETS), .AW(IDX_W), .DW(DATA_W)) u_lane (
        .clk   (clk),
        .we    (lane_we),
        .waddr (lat_idx),
        .wdata (lane_wd),
        .raddr (rd_idx),
        .rdata (lane_rd[w][l])
      );
    end
  end

  cache2w_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (lat_idx),
    .evict_way (lru_evict),
    .upd_en    (lru_upd),
    .upd_idx   (lat_idx),
    .used_way  (lru_way)
  );

  // ---------------- lookup decode ----------------
  assign any_hit  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign hit_word = lane_rd[hit_way][lat_off];
  // empty ways are taken before the LRU marker is consulted
  assign victim   = !way_valid[0] ? 1'b0 :
                    !way_valid[1] ? 1'b1 : lru_evict;
  assign fill_we  = (state == ST_FILL) && mem_ack;
  assign wr_hit   = (state == ST_LOOK) && lat_write && any_hit;
  assign lru_upd  = ((state == ST_LOOK) && any_hit) || fill_we;
  assign lru_way  = fill_we ? victim_q : hit_way;

  // ---------------- control sequence ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
      missed_q  <= 1'b0;
      victim_q  <= 1'b0;
      rdata_q   <= '0;
      hit_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            missed_q  <= 1'b0;
            state     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (any_hit) begin
            if (lat_write) begin
              state <= ST_WMEM;
            end else begin
              rdata_q <= hit_word;
              hit_q   <= !missed_q;
              state   <= ST_DONE;
            end
          end else begin
            victim_q <= victim;
            missed_q <= 1'b1;
            state    <= ST_FILL;
          end
        end
        ST_FILL:   if (mem_ack) state <= ST_RELOOK;
        ST_RELOOK: state <= ST_LOOK;
        ST_WMEM: begin
          if (mem_ack) begin
            rdata_q <= lat_wdata;
            hit_q   <= !missed_q;
            state   <= ST_DONE;
          end
        end
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign req_done  = (state == ST_DONE);
  assign req_rdata = rdata_q;
  assign req_hit   = hit_q;
  assign mem_req   = (state == ST_FILL) || (state == ST_WMEM);
  assign mem_we    = (state == ST_WMEM);
  assign mem_addr  = (state == ST_FILL) ? {lat_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                                        : lat_addr;
  assign mem_wdata = lat_wdata;

  // ---------------- assertions ----------------
  assert_fill_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  assert_no_mem_at_done_R10: assert property (@(posedge clk) disable iff (rst)
    req_done |-> !mem_req);

  assert_one_way_match_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(hit_vec));

  assert_fill_completes_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RELOOK) |=> any_hit);
endmodule

// File: tb/cache2w_ctrl_bench.sv
module cache2w_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_done;
  logic [DW-1:0] req_rdata;
  logic          req_hit;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW*NW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  cache2w_ctrl u_cache2w_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .req_hit(req_hit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int lat = 2;
  int wait_cnt = 0;
  int fill_cnt = 0;
  int wr_cnt = 0;
  int last_cyc = 0;
  logic [AW-1:0] last_fill = '0;
  logic [DW-1:0] fmem [0:65535];
  logic [DW-1:0] gold [int];

  function automatic logic [DW-1:0] base_word(input logic [AW-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    if (gold.exists(int'(a))) return gold[int'(a)];
    return base_word(a);
  endfunction

  initial begin
    for (int i = 0; i < 65536; i++) fmem[i] = base_word(AW'(i));
  end

  // backing memory: acknowledges after lat cycles
  always @(posedge clk) begin
    if (rst) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          fmem[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          for (int l = 0; l < NW; l++)
            mem_rdata[l*DW +: DW] <= fmem[{mem_addr[AW-1:2], 2'(l)}];
          fill_cnt  <= fill_cnt + 1;
          last_fill <= mem_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit exp_hit, input string rq);
    int f0;
    int w0;
    int cyc;
    logic [DW-1:0] exp;
    f0 = fill_cnt;
    w0 = wr_cnt;
    cyc = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_done && cyc < 5000);
    req_valid = 1'b0;
    last_cyc = cyc;
    chk(req_done, rq, "completion", 32'(req_done), 32'd1);
    chk(req_hit == exp_hit, rq, "hit flag", 32'(req_hit), 32'(exp_hit));
    chk((fill_cnt - f0) == (exp_hit ? 0 : 1), rq, "line fetches",
        32'(fill_cnt - f0), exp_hit ? 32'd0 : 32'd1);
    chk((wr_cnt - w0) == (wr ? 1 : 0), rq, "memory writes",
        32'(wr_cnt - w0), wr ? 32'd1 : 32'd0);
    if (wr) begin
      gold[int'(a)] = d;
      chk(fmem[a] == d, rq, "write-through value", fmem[a], d);
    end else begin
      exp = expect_word(a);
      chk(req_rdata == exp, rq, "read data", req_rdata, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_done, "R1", "done after reset", 32'(req_done), 32'd0);
    chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
    access(1'b0, 16'h0000, '0, 1'b0, "R1");
    chk(last_fill == 16'h0000, "R3", "fill address", 32'(last_fill), 32'h0000);
  endtask

  task automatic t_hit_same_line();
    access(1'b0, 16'h0003, '0, 1'b1, "R4");
    access(1'b0, 16'h0002, '0, 1'b1, "R4");
  endtask

  task automatic t_set_pairs();
    access(1'b0, 16'h0101, '0, 1'b0, "R5");
    chk(last_fill == 16'h0100, "R3", "aligned fill address", 32'(last_fill), 32'h0100);
    access(1'b0, 16'h0001, '0, 1'b1, "R5");
    access(1'b0, 16'h0102, '0, 1'b1, "R5");
    access(1'b0, 16'h0014, '0, 1'b0, "R5");
    access(1'b0, 16'h0114, '0, 1'b0, "R5");
    access(1'b0, 16'h0017, '0, 1'b1, "R5");
    access(1'b0, 16'h0115, '0, 1'b1, "R5");
  endtask

  task automatic t_evict();
    // set 0 holds blocks 0 and 64, block 0 least recent
    access(1'b0, 16'h0200, '0, 1'b0, "R6");
    access(1'b0, 16'h0103, '0, 1'b1, "R6");
    access(1'b0, 16'h0000, '0, 1'b0, "R6");
  endtask

  task automatic t_lru_update();
    access(1'b0, 16'h0028, '0, 1'b0, "R7");
    access(1'b0, 16'h0128, '0, 1'b0, "R7");
    access(1'b0, 16'h0029, '0, 1'b1, "R7");
    access(1'b0, 16'h0228, '0, 1'b0, "R7");
    access(1'b0, 16'h002A, '0, 1'b1, "R7");
    access(1'b0, 16'h012B, '0, 1'b0, "R7");
  endtask

  task automatic t_write_hit();
    access(1'b1, 16'h0029, 32'hCAFE_F00D, 1'b1, "R8");
    access(1'b0, 16'h0029, '0, 1'b1, "R8");
    access(1'b0, 16'h0028, '0, 1'b1, "R8");
  endtask

  task automatic t_write_miss();
    access(1'b1, 16'h3346, 32'h1234_5678, 1'b0, "R9");
    access(1'b0, 16'h3346, '0, 1'b1, "R9");
    access(1'b0, 16'h3345, '0, 1'b1, "R9");
  endtask

  task automatic t_split();
    access(1'b0, 16'hFF3C, '0, 1'b0, "R2");
    access(1'b0, 16'h003C, '0, 1'b0, "R2");
    access(1'b0, 16'hFF3F, '0, 1'b1, "R2");
    access(1'b0, 16'h003E, '0, 1'b1, "R2");
  endtask

  task automatic t_stall();
    lat = 25;
    access(1'b0, 16'h7770, '0, 1'b0, "R10");
    chk(last_cyc > 25, "R10", "stall cycles on fill", 32'(last_cyc), 32'd26);
    access(1'b1, 16'h7771, 32'h0BAD_BEEF, 1'b1, "R10");
    chk(last_cyc > 25, "R10", "stall cycles on write", 32'(last_cyc), 32'd26);
    @(negedge clk);
    chk(!req_done, "R10", "done is one pulse", 32'(req_done), 32'd0);
    lat = 2;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_hit_same_line();
    t_set_pairs();
    t_evict();
    t_lru_update();
    t_write_hit();
    t_write_miss();
    t_split();
    t_stall();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule